// File: doc/BRIEF.md
# Two-Wire Bus Condition Tracker

This block sits next to a slave receiver on a two-wire serial bus (I2C) and follows the bus without driving it. Both lines pass through synchronisers clocked by the system clock. Changes between successive synchronised samples are sorted into two kinds. SDA moving while SCL stays high is a bus condition, either a frame start or a frame end. An SCL edge is a clock edge. A small frame state machine acts on these events. It gives the receiver one-cycle start, repeated-start and stop pulses, a busy level, and a strobe on every SCL rising edge inside a frame. The strobe carries the sampled data value and the bit's position within the 9-bit group.

Real buses do not always follow the rules, so the tracker is built to keep working through them. A stop that comes in the same SCL high phase as the start before it would make an empty frame. It is refused and flagged as an error instead. SCL activity while the bus is idle is ignored. Any chain of stop and start conditions leaves the machine in a known state, so the next valid start always puts it back in step with the bus.

Top module: `bus_cond_tracker`

## Requirements
- R1: The synchronised view of each line lags the pins by SYNC_STAGES system clocks. A condition that appears on the pins just before clock edge j is reported in the output pulse that is visible after edge j+SYNC_STAGES.
- R2: SDA falling while SCL stays high produces a one-cycle `start_o` pulse, and `busy_o` is 1 from that cycle on.
- R3: SDA rising while SCL stays high produces a one-cycle `stop_o` pulse and clears `busy_o`, unless the stop is an empty frame (R6). A stop seen while idle also pulses `stop_o` and leaves `busy_o` at 0.
- R4: A start seen while `busy_o` is 1 pulses `rstart_o` together with `start_o`. It restarts the bit position at 0 and does not pulse `stop_o`.
- R5: A stop followed by a start within one unbroken SCL high phase is reported as two conditions: `stop_o` first, then `start_o` without `rstart_o`.
- R6: A stop with no SCL low phase since the last start pulses `err_o` instead of `stop_o`, and `busy_o` stays 1.
- R7: While busy, each SCL rising edge gives a one-cycle `bit_stb_o`. `bit_val_o` holds the synchronised SDA value and `bit_idx_o` holds the bit position. Positions run 0 to 8 and then wrap to 0. Both fields keep their value between strobes.
- R8: While idle, SCL edges produce no `bit_stb_o` and do not change `busy_o`.
- R9: When SDA and SCL change in the same synchronised sample, no condition is decoded. The event counts only as an SCL edge.
- R10: A synchronous active-high reset clears every output and puts the tracker in the idle state.
- R11: After any sequence of stop and start conditions, legal or not, a valid start sets `busy_o`, and the next strobe carries `bit_idx_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| sda_i | input | 1 | Raw SDA line |
| scl_i | input | 1 | Raw SCL line |
| start_o | output | 1 | One-cycle pulse for every start condition |
| rstart_o | output | 1 | One-cycle pulse when that start came inside a frame |
| stop_o | output | 1 | One-cycle pulse for an accepted stop |
| err_o | output | 1 | One-cycle pulse for a refused empty-frame stop |
| busy_o | output | 1 | 1 while a frame is open |
| bit_stb_o | output | 1 | One-cycle strobe per SCL rising edge inside a frame |
| bit_val_o | output | 1 | Sampled SDA value of the last strobe |
| bit_idx_o | output | $clog2(BITS_PER_WORD) | Position of the last strobed bit |

## Verification
The bench builds the tracker with SYNC_STAGES = 3 rather than the default 2, and keeps BITS_PER_WORD = 9. A wrong synchroniser depth or a hard-wired two-flop lag therefore shows up as a latency mismatch against the model. The 9-bit group puts the wrap from position 8 back to 0 in reach within two bytes. The reference model sees only the raw pins delayed by the parameter. From that view it predicts every output on every clock: chained stop and start conditions in one high phase, the empty frame, SCL toggling while idle, and the same-sample change of both lines.

// File: rtl/bus_cond_pkg.sv
package bus_cond_pkg;

    typedef struct packed {
        logic sda;
        logic scl;
    } line_t;

    typedef enum logic {
        BUS_IDLE  = 1'b0,
        BUS_FRAME = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_event_t;

    localparam line_t LINE_RELEASED = '{sda: 1'b1, scl: 1'b1};

    function automatic bus_event_t classify(input line_t cur, input line_t prev);
        bus_event_t ev;
        logic scl_moved;
        ev = '0;
        scl_moved = cur.scl ^ prev.scl;
        if (scl_moved) begin
            ev.scl_rise = cur.scl;
            ev.scl_fall = ~cur.scl;
        end else if (cur.scl && (cur.sda != prev.sda)) begin
            ev.start = ~cur.sda;
            ev.stop  = cur.sda;
        end
        return ev;
    endfunction

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync
    import bus_cond_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  line_t raw_i,
    output line_t cur_o,
    output line_t prev_o
);
    line_t chain [STAGES];
    line_t prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= LINE_RELEASED;
                end else if (g == 0) begin
                    chain[g] <= raw_i;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= LINE_RELEASED;
        else     prev_q <= chain[STAGES-1];
    end

    assign cur_o  = chain[STAGES-1];
    assign prev_o = prev_q;

    initial begin
        assert (STAGES >= 2) else $error("STAGES must be at least 2");
    end
endmodule

// File: rtl/bus_event_decode.sv
module bus_event_decode
    import bus_cond_pkg::*;
(
    input  line_t      cur_i,
    input  line_t      prev_i,
    output bus_event_t ev_o
);
    always_comb ev_o = classify(cur_i, prev_i);
endmodule

// File: rtl/bus_frame_fsm.sv
module bus_frame_fsm
    import bus_cond_pkg::*;
#(
    parameter int BITS_PER_WORD = 9,
    localparam int IDX_W = $clog2(BITS_PER_WORD)
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_event_t       ev_i,
    input  logic             sda_i,
    output logic             start_o,
    output logic             rstart_o,
    output logic             stop_o,
    output logic             err_o,
    output logic             busy_o,
    output logic             bit_stb_o,
    output logic             bit_val_o,
    output logic [IDX_W-1:0] bit_idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS_PER_WORD - 1);

    bus_state_e       state_q;
    logic             low_seen_q;
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= BUS_IDLE;
            low_seen_q <= 1'b0;
            cnt_q      <= '0;
            start_o    <= 1'b0;
            rstart_o   <= 1'b0;
            stop_o     <= 1'b0;
            err_o      <= 1'b0;
            bit_stb_o  <= 1'b0;
            bit_val_o  <= 1'b0;
            bit_idx_o  <= '0;
        end else begin
            start_o   <= 1'b0;
            rstart_o  <= 1'b0;
            stop_o    <= 1'b0;
            err_o     <= 1'b0;
            bit_stb_o <= 1'b0;
            if (ev_i.start) begin
                start_o    <= 1'b1;
                rstart_o   <= (state_q == BUS_FRAME);
                state_q    <= BUS_FRAME;
                cnt_q      <= '0;
                low_seen_q <= 1'b0;
            end else if (ev_i.stop) begin
                if (state_q == BUS_FRAME && !low_seen_q) begin
                    err_o <= 1'b1;
                end else begin
                    stop_o  <= 1'b1;
                    state_q <= BUS_IDLE;
                end
            end else if (state_q == BUS_FRAME) begin
                if (ev_i.scl_fall) low_seen_q <= 1'b1;
                if (ev_i.scl_rise) begin
                    bit_stb_o <= 1'b1;
                    bit_val_o <= sda_i;
                    bit_idx_o <= cnt_q;
                    cnt_q     <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy_o = (state_q == BUS_FRAME);

    assert_start_opens_R2: assert property (@(posedge clk) disable iff (rst)
        start_o |-> busy_o);
    assert_stop_closes_R3: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> !busy_o);
    assert_rstart_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
        rstart_o |-> (start_o && $past(busy_o) && !stop_o));
    assert_empty_keeps_frame_R6: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (busy_o && $past(busy_o) && !stop_o));
    assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
        bit_idx_o <= LAST_IDX);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        bit_stb_o |-> $past(busy_o));
    assert_one_condition_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_o, stop_o, err_o, bit_stb_o}));
endmodule

// File: rtl/bus_cond_tracker.sv
module bus_cond_tracker
    import bus_cond_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int BITS_PER_WORD = 9,
    localparam int IDX_W = $clog2(BITS_PER_WORD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sda_i,
    input  logic             scl_i,
    output logic             start_o,
    output logic             rstart_o,
    output logic             stop_o,
    output logic             err_o,
    output logic             busy_o,
    output logic             bit_stb_o,
    output logic             bit_val_o,
    output logic [IDX_W-1:0] bit_idx_o
);
    line_t      raw_w, cur_w, prev_w;
    bus_event_t ev_w;

    assign raw_w = '{sda: sda_i, scl: scl_i};

    bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw_i(raw_w), .cur_o(cur_w), .prev_o(prev_w)
    );

    bus_event_decode u_decode (
        .cur_i(cur_w), .prev_i(prev_w), .ev_o(ev_w)
    );

    bus_frame_fsm #(.BITS_PER_WORD(BITS_PER_WORD)) u_fsm (
        .clk(clk), .rst(rst), .ev_i(ev_w), .sda_i(cur_w.sda),
        .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o),
        .err_o(err_o), .busy_o(busy_o), .bit_stb_o(bit_stb_o),
        .bit_val_o(bit_val_o), .bit_idx_o(bit_idx_o)
    );

    assert_clean_after_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> !(start_o || stop_o || err_o || bit_stb_o || busy_o));
endmodule

// File: tb/bus_cond_tracker_test.sv
module bus_cond_tracker_test;
    localparam int S   = 3;
    localparam int BPW = 9;
    localparam int IW  = $clog2(BPW);
    localparam int H   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sda = 1'b1;
    logic scl = 1'b1;
    logic start_o, rstart_o, stop_o, err_o, busy_o, bit_stb_o, bit_val_o;
    logic [IW-1:0] bit_idx_o;

    int n_checks = 0;
    int n_fail   = 0;
    int c_start = 0, c_rstart = 0, c_stop = 0, c_err = 0, c_stb = 0;

    always #5 clk = ~clk;

    bus_cond_tracker #(.SYNC_STAGES(S), .BITS_PER_WORD(BPW)) uut (
        .clk(clk), .rst(rst), .sda_i(sda), .scl_i(scl),
        .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o), .err_o(err_o),
        .busy_o(busy_o), .bit_stb_o(bit_stb_o), .bit_val_o(bit_val_o),
        .bit_idx_o(bit_idx_o)
    );

    // behavioural reference: history of pin samples, frame flags
    logic [1:0] hist[$];
    logic m_active, m_low, m_start, m_rstart, m_stop, m_err, m_stb, m_val;
    int   m_cnt, m_idx;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            for (int i = 0; i < S + 2; i++) hist.push_back(2'b11);
            m_active = 0; m_low = 0; m_cnt = 0; m_idx = 0; m_val = 0;
            m_start = 0; m_rstart = 0; m_stop = 0; m_err = 0; m_stb = 0;
        end else begin
            logic [1:0] cur, prv;
            hist.push_back({sda, scl});
            void'(hist.pop_front());
            cur = hist[hist.size() - 1 - S];
            prv = hist[hist.size() - 2 - S];
            m_start = 0; m_rstart = 0; m_stop = 0; m_err = 0; m_stb = 0;
            if (cur[0] != prv[0]) begin
                if (m_active) begin
                    if (!cur[0]) m_low = 1;
                    else begin
                        m_stb = 1; m_val = cur[1]; m_idx = m_cnt;
                        m_cnt = (m_cnt == BPW - 1) ? 0 : m_cnt + 1;
                    end
                end
            end else if (cur[0] && cur[1] != prv[1]) begin
                if (!cur[1]) begin
                    m_start = 1; m_rstart = m_active; m_active = 1; m_cnt = 0; m_low = 0;
                end else if (m_active && !m_low) begin
                    m_err = 1;
                end else begin
                    m_stop = 1; m_active = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R2", "start_o", start_o, m_start);
            check("R4", "rstart_o", rstart_o, m_rstart);
            check("R3", "stop_o", stop_o, m_stop);
            check("R6", "err_o", err_o, m_err);
            check("R8", "busy_o", busy_o, m_active);
            check("R7", "bit_stb_o", bit_stb_o, m_stb);
            check("R7", "bit_val_o", bit_val_o, m_val);
            check("R7", "bit_idx_o", int'(bit_idx_o), m_idx);
            c_start += start_o; c_rstart += rstart_o; c_stop += stop_o;
            c_err += err_o; c_stb += bit_stb_o;
        end
    end

    task automatic drive(input logic d, input logic c, input int n);
        @(negedge clk);
        sda = d; scl = c;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic settle();
        repeat (S + 3) @(negedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [8:0] v);
        for (int i = 8; i >= 0; i--) begin
            drive(v[i], 1'b0, H);
            drive(v[i], 1'b1, H);
        end
        drive(v[0], 1'b0, H);
    endtask

    initial begin
        int lat, s0, t0, r0, e0, b0;
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        check("R10", "busy after reset", busy_o, 0);
        check("R10", "pulses after reset", start_o | stop_o | err_o | bit_stb_o, 0);
        @(negedge clk); rst = 1'b0;
        drive(1'b1, 1'b1, H);

        // R1: latency of the start pulse
        @(negedge clk); sda = 1'b0;
        lat = -1;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk); #1;
            if (start_o && lat < 0) lat = i;
        end
        check("R1", "start latency", lat, S + 1);
        check("R2", "busy after start", busy_o, 1);

        // R7: two 9-bit groups, index wraps
        b0 = c_stb;
        send_bits(9'b1010_0101_0);
        send_bits(9'b0110_1100_1);
        settle();
        check("R7", "strobes in two groups", c_stb - b0, 18);
        check("R7", "last index", int'(bit_idx_o), 8);

        // R4: repeated start inside frame
        r0 = c_rstart; t0 = c_stop;
        drive(1'b1, 1'b0, H); drive(1'b1, 1'b1, H); drive(1'b0, 1'b1, H);
        settle();
        check("R4", "rstart count", c_rstart - r0, 1);
        check("R4", "no stop on rstart", c_stop - t0, 0);
        drive(1'b0, 1'b0, H); drive(1'b1, 1'b1, H); drive(1'b1, 1'b0, H);
        settle();
        check("R4", "index restarts", int'(bit_idx_o), 0);

        // R3 + R5: stop then start in one high phase
        s0 = c_start; t0 = c_stop; r0 = c_rstart;
        drive(1'b0, 1'b0, H); drive(1'b0, 1'b1, H);
        drive(1'b1, 1'b1, H); drive(1'b0, 1'b1, H);
        settle();
        check("R5", "stop count", c_stop - t0, 1);
        check("R5", "start count", c_start - s0, 1);
        check("R5", "no rstart", c_rstart - r0, 0);
        check("R5", "busy after pair", busy_o, 1);

        // R3: regular stop ends frame
        drive(1'b0, 1'b0, H); drive(1'b0, 1'b1, H); drive(1'b1, 1'b1, H);
        settle();
        check("R3", "busy after stop", busy_o, 0);

        // R8: SCL toggling while idle
        b0 = c_stb; s0 = c_start;
        for (int i = 0; i < 10; i++) begin
            drive(1'b1, 1'b0, 4); drive(1'b1, 1'b1, 4);
        end
        settle();
        check("R8", "idle strobes", c_stb - b0, 0);
        check("R8", "idle busy", busy_o, 0);
        check("R8", "idle starts", c_start - s0, 0);

        // R6: empty frame
        e0 = c_err; t0 = c_stop;
        drive(1'b0, 1'b1, H); drive(1'b1, 1'b1, H);
        settle();
        check("R6", "err count", c_err - e0, 1);
        check("R6", "no stop", c_stop - t0, 0);
        check("R6", "frame kept", busy_o, 1);

        // R9: both lines change together -> SCL edge only
        drive(1'b0, 1'b0, H);
        t0 = c_stop; b0 = c_stb;
        drive(1'b1, 1'b1, H);
        settle();
        check("R9", "no stop", c_stop - t0, 0);
        check("R9", "one strobe", c_stb - b0, 1);
        check("R9", "strobe value", bit_val_o, 1);

        // R11: chained stop/start conditions then valid start
        drive(1'b0, 1'b0, H); drive(1'b0, 1'b1, H);
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, 1'b1, 3); drive(1'b0, 1'b1, 3);
        end
        drive(1'b1, 1'b1, H);
        drive(1'b0, 1'b1, H);
        settle();
        check("R11", "busy after resync", busy_o, 1);
        drive(1'b0, 1'b0, H); drive(1'b1, 1'b1, H); drive(1'b1, 1'b0, H);
        settle();
        check("R11", "first index", int'(bit_idx_o), 0);
        drive(1'b0, 1'b0, H); drive(1'b0, 1'b1, H); drive(1'b1, 1'b1, H);
        settle();
        check("R3", "final idle", busy_o, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule